// File: doc/BRIEF.md
# Receive Message Object Store

This block keeps a bank of message objects for a controller-area-network receiver and files every accepted incoming frame into one of them. Each object carries a stored identifier, an acceptance mask, configuration flags (valid, receive direction, end-of-buffer, receive interrupt enable, transmit request) and status flags (new-data, message-lost, interrupt-pending), plus the data length code and up to eight data bytes of the last frame stored there.

When the receiver presents a frame, the store compares it against every object at once. It then picks the lowest-numbered object that both matches and is free to take the frame, and writes the frame into it. Objects that share one filter form a receive FIFO. Each entry locks itself through its new-data flag, and the entry whose end-of-buffer flag is set serves as the overflow slot that is overwritten once every earlier entry is locked. Software configures objects through a write port, acknowledges them through a flag-clear port, and inspects any object through a combinational read port.

Top module: `rx_msg_store`

## Requirements
- R1: When several objects can take a frame, the one with the lowest index receives it.
- R2: An object matches a frame only when it is valid, its receive flag is 1, and every identifier bit whose mask bit is 1 equals the corresponding frame bit. Mask bits that are 0 are don't-care.
- R3: A stored object holds the full received identifier (not the masked one), together with the frame's data length code and data.
- R4: Storing a frame sets the object's new-data flag. It sets interrupt-pending only when the object's receive interrupt enable is 1.
- R5: A matching object with new-data 1 and end-of-buffer 0 is locked and is skipped. The frame goes to the lowest-numbered matching object whose new-data is 0, and a cleared entry becomes eligible again.
- R6: When every earlier matching object is locked, the frame overwrites the matching object with end-of-buffer 1, and that object's message-lost flag is set if its new-data was already 1.
- R7: Message-lost stays 1 across further frames and new-data clears, and it returns to 0 only through the flag-clear port.
- R8: Storing a frame into an object clears its transmit-request flag.
- R9: A frame that no object can take is dropped. Done still pulses with hit 0, and no object changes.
- R10: Done pulses exactly two clock cycles after the receive strobe is sampled. A strobe may be applied on every cycle, and each later frame sees the effect of the earlier one.
- R11: The flag-clear port clears the selected object's new-data, message-lost and interrupt-pending flags, each under its own enable bit, one cycle after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write object configuration |
| cfg_idx | input | 5 | Object to configure |
| cfg_id | input | 29 | Filter identifier |
| cfg_mask | input | 29 | Acceptance mask, 1 = compare bit |
| cfg_valid | input | 1 | Object in use |
| cfg_rx | input | 1 | 1 = receive object |
| cfg_eob | input | 1 | End-of-buffer flag |
| cfg_rxie | input | 1 | Receive interrupt enable |
| cfg_txrqst | input | 1 | Transmit (remote) request flag |
| clr_we | input | 1 | Apply flag clear |
| clr_idx | input | 5 | Object whose flags are cleared |
| clr_newdat | input | 1 | Clear new-data |
| clr_msglst | input | 1 | Clear message-lost |
| clr_intpnd | input | 1 | Clear interrupt-pending |
| rx_valid | input | 1 | Received frame strobe |
| rx_id | input | 29 | Received identifier |
| rx_dlc | input | 4 | Received data length code |
| rx_data | input | 64 | Received data bytes |
| done_o | output | 1 | Frame handling complete |
| hit_o | output | 1 | Frame was stored |
| hit_idx_o | output | 5 | Object that took the frame |
| rd_idx | input | 5 | Object to observe |
| rd_id | output | 29 | Stored identifier |
| rd_dlc | output | 4 | Stored data length code |
| rd_data | output | 64 | Stored data |
| rd_newdat | output | 1 | New-data flag |
| rd_msglst | output | 1 | Message-lost flag |
| rd_intpnd | output | 1 | Interrupt-pending flag |
| rd_txrqst | output | 1 | Transmit-request flag |

## Verification
A wrong lock or priority decision shows on the same done pulse that reports the object index, two cycles after the strobe. A flag that is mis-set or left stale shows on the read port one cycle after the store or clear that should have changed it. A corrupted message-lost or new-data state inside a FIFO usually stays hidden until the next frame for that filter. That frame then lands in the wrong entry, so the bench sends frame sequences that revisit each chain after every clear.

// File: rtl/rxstore_pkg.sv
package rxstore_pkg;
    localparam int NOBJ  = 32;
    localparam int IDW   = 29;
    localparam int DLCW  = 4;
    localparam int DATAW = 64;
    localparam int IXW   = $clog2(NOBJ);

    typedef struct packed {
        logic             valid;
        logic             rx;
        logic             eob;
        logic             rxie;
        logic             txrqst;
        logic             newdat;
        logic             msglst;
        logic             intpnd;
        logic [IDW-1:0]   id;
        logic [IDW-1:0]   mask;
        logic [DLCW-1:0]  dlc;
        logic [DATAW-1:0] data;
    } obj_t;

    typedef struct packed {
        logic [IDW-1:0]   id;
        logic [DLCW-1:0]  dlc;
        logic [DATAW-1:0] data;
    } frame_t;
endpackage

// File: rtl/rxs_filter.sv
module rxs_filter
    import rxstore_pkg::*;
(
    input  obj_t [NOBJ-1:0]   objs,
    input  logic [IDW-1:0]    id,
    output logic [NOBJ-1:0]   elig
);
    for (genvar g = 0; g < NOBJ; g++) begin : g_obj
        logic hit;
        assign hit = objs[g].valid && objs[g].rx &&
                     (((id ^ objs[g].id) & objs[g].mask) == '0);
        // a locked entry (new data pending, not last of chain) refuses frames
        assign elig[g] = hit && (!objs[g].newdat || objs[g].eob);
    end
endmodule

// File: rtl/rxs_pick.sv
module rxs_pick #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
    assign found = |req;
endmodule

// File: rtl/rx_msg_store.sv
module rx_msg_store
    import rxstore_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IXW-1:0]   cfg_idx,
    input  logic [IDW-1:0]   cfg_id,
    input  logic [IDW-1:0]   cfg_mask,
    input  logic             cfg_valid,
    input  logic             cfg_rx,
    input  logic             cfg_eob,
    input  logic             cfg_rxie,
    input  logic             cfg_txrqst,
    input  logic             clr_we,
    input  logic [IXW-1:0]   clr_idx,
    input  logic             clr_newdat,
    input  logic             clr_msglst,
    input  logic             clr_intpnd,
    input  logic             rx_valid,
    input  logic [IDW-1:0]   rx_id,
    input  logic [DLCW-1:0]  rx_dlc,
    input  logic [DATAW-1:0] rx_data,
    output logic             done_o,
    output logic             hit_o,
    output logic [IXW-1:0]   hit_idx_o,
    input  logic [IXW-1:0]   rd_idx,
    output logic [IDW-1:0]   rd_id,
    output logic [DLCW-1:0]  rd_dlc,
    output logic [DATAW-1:0] rd_data,
    output logic             rd_newdat,
    output logic             rd_msglst,
    output logic             rd_intpnd,
    output logic             rd_txrqst
);
    typedef struct packed {
        obj_t [NOBJ-1:0] objs;
        frame_t          frm;
        logic            frm_v;
        logic            done;
        logic            hit;
        logic [IXW-1:0]  idx;
    } st_t;

    st_t             st_d, st_q;
    obj_t [NOBJ-1:0] objs_q;
    logic [NOBJ-1:0] elig;
    logic            found;
    logic [IXW-1:0]  pick;

    assign objs_q = st_q.objs;

    rxs_filter u_filter (
        .objs (objs_q),
        .id   (st_q.frm.id),
        .elig (elig)
    );

    rxs_pick #(.N(NOBJ), .IW(IXW)) u_pick (
        .req   (elig),
        .found (found),
        .idx   (pick)
    );

    always_comb begin
        st_d = st_q;

        // stage 1: capture the incoming frame
        st_d.frm_v = rx_valid;
        if (rx_valid) begin
            st_d.frm = '{id: rx_id, dlc: rx_dlc, data: rx_data};
        end

        // stage 2 result
        st_d.done = st_q.frm_v;
        st_d.hit  = st_q.frm_v && found;
        st_d.idx  = (st_q.frm_v && found) ? pick : '0;

        if (cfg_we) begin
            st_d.objs[cfg_idx].valid  = cfg_valid;
            st_d.objs[cfg_idx].rx     = cfg_rx;
            st_d.objs[cfg_idx].eob    = cfg_eob;
            st_d.objs[cfg_idx].rxie   = cfg_rxie;
            st_d.objs[cfg_idx].txrqst = cfg_txrqst;
            st_d.objs[cfg_idx].id     = cfg_id;
            st_d.objs[cfg_idx].mask   = cfg_mask;
            st_d.objs[cfg_idx].newdat = 1'b0;
            st_d.objs[cfg_idx].msglst = 1'b0;
            st_d.objs[cfg_idx].intpnd = 1'b0;
        end

        if (clr_we) begin
            if (clr_newdat) st_d.objs[clr_idx].newdat = 1'b0;
            if (clr_msglst) st_d.objs[clr_idx].msglst = 1'b0;
            if (clr_intpnd) st_d.objs[clr_idx].intpnd = 1'b0;
        end

        // stage 2: store into the chosen object; a store wins over a
        // configuration write or flag clear aimed at the same object
        if (st_q.frm_v && found) begin
            st_d.objs[pick].msglst = st_d.objs[pick].msglst | st_q.objs[pick].newdat;
            st_d.objs[pick].newdat = 1'b1;
            st_d.objs[pick].intpnd = st_d.objs[pick].intpnd | st_d.objs[pick].rxie;
            st_d.objs[pick].txrqst = 1'b0;
            st_d.objs[pick].id     = st_q.frm.id;
            st_d.objs[pick].dlc    = st_q.frm.dlc;
            st_d.objs[pick].data   = st_q.frm.data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o    = st_q.done;
    assign hit_o     = st_q.hit;
    assign hit_idx_o = st_q.idx;
    assign rd_id     = st_q.objs[rd_idx].id;
    assign rd_dlc    = st_q.objs[rd_idx].dlc;
    assign rd_data   = st_q.objs[rd_idx].data;
    assign rd_newdat = st_q.objs[rd_idx].newdat;
    assign rd_msglst = st_q.objs[rd_idx].msglst;
    assign rd_intpnd = st_q.objs[rd_idx].intpnd;
    assign rd_txrqst = st_q.objs[rd_idx].txrqst;
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker
    import rxstore_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_valid,
    input  logic            done_o,
    input  logic            hit_o,
    input  logic [IXW-1:0]  hit_idx_o,
    input  obj_t [NOBJ-1:0] objs
);
    // R10: fixed two-cycle completion
    assert_done_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ##2 done_o);

    // R9: a hit is only reported together with done
    assert_hit_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> !hit_o);

    // R4: the object reported as taking the frame shows new data
    assert_newdat_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && hit_o) |-> objs[hit_idx_o].newdat);

    // R8: the storing object no longer requests a transmission
    assert_txrqst_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && hit_o) |-> !objs[hit_idx_o].txrqst);

    // R2: the chosen object is a valid receive object
    assert_target_is_rx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && hit_o) |-> (objs[hit_idx_o].valid && objs[hit_idx_o].rx));
endmodule

bind rx_msg_store rxs_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .done_o    (done_o),
    .hit_o     (hit_o),
    .hit_idx_o (hit_idx_o),
    .objs      (objs_q)
);

// File: tb/tb_rx_msg_store.sv
module tb_rx_msg_store;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 0, cfg_valid = 0, cfg_rx = 0, cfg_eob = 0, cfg_rxie = 0, cfg_txrqst = 0;
    logic [4:0]  cfg_idx = 0, clr_idx = 0, rd_idx = 0;
    logic [28:0] cfg_id = 0, cfg_mask = 0, rx_id = 0;
    logic        clr_we = 0, clr_newdat = 0, clr_msglst = 0, clr_intpnd = 0;
    logic        rx_valid = 0;
    logic [3:0]  rx_dlc = 0;
    logic [63:0] rx_data = 0;
    logic        done_o, hit_o, rd_newdat, rd_msglst, rd_intpnd, rd_txrqst;
    logic [4:0]  hit_idx_o;
    logic [28:0] rd_id;
    logic [3:0]  rd_dlc;
    logic [63:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    rx_msg_store dut (.*);

    typedef struct packed {
        logic [28:0] id;
        logic        hit;
        logic [4:0]  idx;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{29'h100,      1'b1, 5'd0},   // R5 FIFO first entry
        '{29'h100,      1'b1, 5'd1},   // R5 entry 0 locked
        '{29'h100,      1'b1, 5'd2},
        '{29'h100,      1'b1, 5'd3},   // R6 last entry
        '{29'h100,      1'b1, 5'd3},   // R6 overwrite
        '{29'h0ABCDE42, 1'b1, 5'd5},   // R2 masked match
        '{29'h205,      1'b1, 5'd8},   // R1 obj 8 beats obj 9
        '{29'h20A,      1'b1, 5'd8},   // R2 low nibble don't care
        '{29'h300,      1'b0, 5'd0},   // R9 invalid object
        '{29'h301,      1'b0, 5'd0},   // R9 transmit object
        '{29'h555,      1'b0, 5'd0}    // R9 no filter
    };

    function automatic logic [63:0] dat(input int k);
        return (64'(k) * 64'h0101_0101_0101_0101) ^ 64'hDEAD_BEEF_0000_0000;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input int idx, input logic [28:0] id, input logic [28:0] mask,
                       input logic v, input logic rx, input logic eob,
                       input logic ie, input logic tq);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 5'(idx); cfg_id = id; cfg_mask = mask;
        cfg_valid = v; cfg_rx = rx; cfg_eob = eob; cfg_rxie = ie; cfg_txrqst = tq;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic clr(input int idx, input logic nd, input logic ml, input logic ip);
        @(negedge clk);
        clr_we = 1; clr_idx = 5'(idx); clr_newdat = nd; clr_msglst = ml; clr_intpnd = ip;
        @(negedge clk);
        clr_we = 0;
    endtask

    // send one frame, return done/hit/idx sampled two cycles after the strobe
    task automatic send(input logic [28:0] id, input int k,
                        output logic d, output logic h, output logic [4:0] ix);
        @(negedge clk);
        rx_valid = 1; rx_id = id; rx_dlc = 4'(k + 1); rx_data = dat(k);
        @(negedge clk);
        rx_valid = 0;
        @(negedge clk);
        d = done_o; h = hit_o; ix = hit_idx_o;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic d, h;
        logic [4:0] ix;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        rd_idx = 0;
        #1;
        chk("reset done R10", done_o, 0);
        chk("reset newdat R4", rd_newdat, 0);

        for (int i = 0; i < 4; i++) cfg(i, 29'h100, 29'h1FFF_FFFF, 1, 1, i == 3, 1, 0);
        cfg(5, 29'h0ABCDE00, 29'h1FFF_FF00, 1, 1, 1, 0, 1);
        cfg(8, 29'h200, 29'h1FFF_FFF0, 1, 1, 1, 1, 0);
        cfg(9, 29'h205, 29'h1FFF_FFFF, 1, 1, 1, 1, 0);
        cfg(10, 29'h300, 29'h1FFF_FFFF, 0, 1, 1, 1, 0);
        cfg(11, 29'h301, 29'h1FFF_FFFF, 1, 0, 1, 1, 0);

        for (int k = 0; k < NV; k++) begin
            send(VECS[k].id, k, d, h, ix);
            chk("vector done R10", d, 1);
            chk("vector hit R1 R2 R9", h, VECS[k].hit);
            if (VECS[k].hit) chk("vector index R1 R5 R6", ix, VECS[k].idx);
        end

        @(negedge clk);
        rd_idx = 3; #1;
        chk("overwrite data R6", rd_data, dat(4));
        chk("overwrite dlc R3", rd_dlc, 4'd5);
        chk("msglst on overwrite R6", rd_msglst, 1);
        chk("intpnd with enable R4", rd_intpnd, 1);
        rd_idx = 2; #1;
        chk("no msglst first store R6", rd_msglst, 0);
        rd_idx = 5; #1;
        chk("full id stored R3", rd_id, 29'h0ABCDE42);
        chk("txrqst auto clear R8", rd_txrqst, 0);
        chk("no intpnd without enable R4", rd_intpnd, 0);
        chk("newdat set R4", rd_newdat, 1);
        rd_idx = 9; #1;
        chk("lower priority untouched R1", rd_newdat, 0);
        rd_idx = 10; #1;
        chk("dropped frame no change R9", rd_newdat, 0);
        rd_idx = 11; #1;
        chk("dropped frame no change R9", rd_newdat, 0);

        // release entry 1: next FIFO frame goes there
        clr(1, 1, 0, 0);
        rd_idx = 1; #1;
        chk("newdat cleared R11", rd_newdat, 0);
        chk("intpnd kept R11", rd_intpnd, 1);
        send(29'h100, 20, d, h, ix);
        chk("released entry reused R5", ix, 5'd1);
        chk("no msglst on free entry R6", rd_msglst, 0);

        // message-lost sticky across newdat clear
        clr(3, 1, 0, 1);
        rd_idx = 3; #1;
        chk("msglst sticky R7", rd_msglst, 1);
        chk("intpnd cleared R11", rd_intpnd, 0);

        // back-to-back frames into the last entry
        @(negedge clk);
        rx_valid = 1; rx_id = 29'h100; rx_dlc = 4'd2; rx_data = dat(30);
        @(negedge clk);
        rx_id = 29'h100; rx_data = dat(31);
        @(negedge clk);
        rx_valid = 0;
        chk("back-to-back first done R10", done_o, 1);
        chk("back-to-back first index R6", hit_idx_o, 5'd3);
        @(negedge clk);
        chk("back-to-back second done R10", done_o, 1);
        chk("back-to-back second index R6", hit_idx_o, 5'd3);
        rd_idx = 3; #1;
        chk("second overwrite data R6", rd_data, dat(31));
        chk("msglst still set R7", rd_msglst, 1);
        @(negedge clk);
        chk("done single pulse R10", done_o, 0);

        clr(3, 0, 1, 0);
        rd_idx = 3; #1;
        chk("msglst cleared by port R7", rd_msglst, 0);
        chk("newdat kept R11", rd_newdat, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule